// File: doc/BRIEF.md
# Fixed-Priority Banked Cluster Memory

This block is the shared data store of one processor cluster. Eight cores reach it over dedicated request lines, and no network or bus lies between them. The word storage is split into four banks. Consecutive word addresses fall in different banks, so cores that stream through neighbouring words tend to land on different banks. In each cycle every bank takes at most one access. All banks work in parallel, so up to four accesses complete per cycle.

When several cores want the same bank in the same cycle, the core with the lowest port number wins. Port 0 is the core nearest the top-left of the cluster, and port 7 is the farthest. Each port has a grant output, and it is combinational in the request cycle. A core that is not granted is stalled. That core must present the same request again, unchanged, until it is granted. A granted read returns its word two clock edges after the grant cycle, with a one-cycle valid pulse. A granted write takes effect at the next edge. Byte enables let a write store only 8-bit or 16-bit parts of a word.

Top module: `fpbank_shmem`

## Requirements
- R1: While `rst` is high, `gnt` is all zero whatever the requests are. Once a clock edge has passed with `rst` high, `rvalid` and `rdata` read zero.
- R2: `addr[1:0]` selects the bank, and `addr[AW-1:2]` selects the word inside that bank. Every one of the `DEPTH` word addresses holds its own value.
- R3: A request that no other port shares a bank with is granted in the same cycle (`gnt[p]`=1).
- R4: Requests to different banks in one cycle are all granted in that cycle.
- R5: Among ports that request the same bank in one cycle, only the lowest-numbered one is granted. The others see `gnt`=0.
- R6: A stalled port holds `req`, `we`, `addr`, `wdata` and `be` stable. It is granted once no lower-numbered port still requests its bank. A set of ports that contend for one bank is therefore served one port per cycle, in ascending port order.
- R7: A granted read (`we`=0) in cycle t raises `rvalid[p]` for exactly one cycle. That cycle follows the second rising edge after t. In that cycle `rdata[p]` is the word stored at `addr` at the time of the grant. At all other times `rvalid[p]` is 0 and `rdata[p]` keeps its last value.
- R8: A granted write (`we`=1) updates byte i of the word, meaning bits 8i+7..8i, only where `be[i]`=1. The other bytes keep their old values. A write never raises `rvalid`.
- R9: A granted write with `be`=0 leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NPORTS | Per-port access request |
| we | input | NPORTS | Per-port write (1) or read (0) |
| addr | input | NPORTS x AW | Per-port word address |
| wdata | input | NPORTS x DW | Per-port write data |
| be | input | NPORTS x DW/8 | Per-port byte write enables |
| gnt | output | NPORTS | Grant in the request cycle; 0 means stalled |
| rvalid | output | NPORTS | Read return strobe |
| rdata | output | NPORTS x DW | Read return data |

## Verification
The bench keeps eight ports, four banks and 32-bit words, but it shrinks the depth to 64 words, which gives 16 per bank. With that depth the bench can write and read back every word from rotating ports. It can also drive every one of the 255 non-empty requester sets into a single bank and follow each set until the last stalled port is served. Along the way it checks the grant order and the read-return timing on every cycle. It also applies all 16 byte-enable patterns to one word, and it drives full-width and half-width mixes of bank spreads.

// File: rtl/fpbank_pkg.sv
package fpbank_pkg;
  localparam int unsigned BYTE_W = 8;

  // index of the lowest set bit (0 when none set)
  function automatic int unsigned low_idx(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/fpbank_arb.sv
module fpbank_arb #(
  parameter int unsigned NPORTS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPORTS-1:0] hit,
  output logic [NPORTS-1:0] gnt
);
  // lowest set bit wins
  assign gnt = hit & (~hit + NPORTS'(1));

  // R5
  one_winner_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R5
  winner_requested_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~hit) == '0);
  // R3
  bank_not_idle_chk: assert property (@(posedge clk) disable iff (rst) (|hit) |-> (|gnt));
endmodule

// File: rtl/fpbank_ram.sv
module fpbank_ram #(
  parameter int unsigned WORDS = 2048,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned NB   = DW / fpbank_pkg::BYTE_W
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [NB-1:0] be,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int i = 0; i < NB; i++) begin
          if (be[i]) store[addr][i*fpbank_pkg::BYTE_W +: fpbank_pkg::BYTE_W] <= wdata[i*fpbank_pkg::BYTE_W +: fpbank_pkg::BYTE_W];
        end
      end else begin
        rdata <= store[addr];
      end
    end
  end
endmodule

// File: rtl/fpbank_shmem.sv
module fpbank_shmem #(
  parameter int unsigned NPORTS = 8,
  parameter int unsigned NBANKS = 4,
  parameter int unsigned DEPTH  = 8192,
  parameter int unsigned DW     = 32,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned NB    = DW / fpbank_pkg::BYTE_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NPORTS-1:0]            req,
  input  logic [NPORTS-1:0]            we,
  input  logic [NPORTS-1:0][AW-1:0]    addr,
  input  logic [NPORTS-1:0][DW-1:0]    wdata,
  input  logic [NPORTS-1:0][NB-1:0]    be,
  output logic [NPORTS-1:0]            gnt,
  output logic [NPORTS-1:0]            rvalid,
  output logic [NPORTS-1:0][DW-1:0]    rdata
);
  localparam int unsigned BW    = $clog2(NBANKS);
  localparam int unsigned BAW   = AW - BW;
  localparam int unsigned BDEPTH = DEPTH / NBANKS;
  localparam int unsigned PW    = $clog2(NPORTS);

  logic [NPORTS-1:0] hit  [NBANKS];
  logic [NPORTS-1:0] bgnt [NBANKS];
  logic [DW-1:0]     brd  [NBANKS];

  // request decode: low address bits pick the bank
  always_comb begin
    for (int b = 0; b < NBANKS; b++) begin
      for (int p = 0; p < NPORTS; p++) begin
        hit[b][p] = req[p] && !rst && (addr[p][BW-1:0] == BW'(b));
      end
    end
  end

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic [PW-1:0]  sel;
    logic [BAW-1:0] baddr;
    logic           ben;

    fpbank_arb #(.NPORTS(NPORTS)) u_arb (
      .clk (clk),
      .rst (rst),
      .hit (hit[b]),
      .gnt (bgnt[b])
    );

    always_comb begin
      sel   = PW'(fpbank_pkg::low_idx(32'(bgnt[b])));
      ben   = |bgnt[b];
      baddr = addr[sel][AW-1:BW];
    end

    fpbank_ram #(.WORDS(BDEPTH), .DW(DW)) u_ram (
      .clk   (clk),
      .en    (ben),
      .we    (we[sel]),
      .be    (be[sel]),
      .addr  (baddr),
      .wdata (wdata[sel]),
      .rdata (brd[b])
    );
  end

  always_comb begin
    gnt = '0;
    for (int b = 0; b < NBANKS; b++) gnt |= bgnt[b];
  end

  // read return pipeline: bank register, then port register
  logic [NPORTS-1:0]         rv1;
  logic [NPORTS-1:0][BW-1:0] rbank;

  always_ff @(posedge clk) begin
    if (rst) begin
      rv1    <= '0;
      rbank  <= '0;
      rvalid <= '0;
      rdata  <= '0;
    end else begin
      rv1    <= gnt & ~we;
      rvalid <= rv1;
      for (int p = 0; p < NPORTS; p++) begin
        rbank[p] <= addr[p][BW-1:0];
        if (rv1[p]) rdata[p] <= brd[rbank[p]];
      end
    end
  end

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid == $past(gnt & ~we, 2));

  for (genvar p = 0; p < NPORTS; p++) begin : g_hold
    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (req[p] && !gnt[p]) |=> (req[p] && $stable(we[p]) && $stable(addr[p]) &&
                               $stable(wdata[p]) && $stable(be[p])));
  end
endmodule

// File: tb/fpbank_shmem_test.sv
module fpbank_shmem_test;
  localparam int NP = 8;
  localparam int DEP = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst;
  logic [NP-1:0] req, we;
  logic [NP-1:0][AW-1:0] addr;
  logic [NP-1:0][31:0] wdata;
  logic [NP-1:0][3:0] be;
  logic [NP-1:0] gnt, rvalid;
  logic [NP-1:0][31:0] rdata;

  always #5 clk = ~clk;

  fpbank_shmem #(.NPORTS(8), .NBANKS(4), .DEPTH(DEP), .DW(32)) uut (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .be(be), .gnt(gnt), .rvalid(rvalid), .rdata(rdata)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] mdl [DEP];
  logic [NP-1:0] pg;
  logic [31:0] pd [NP];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clr();
    req = '0; we = '0; addr = '0; wdata = '0; be = '0;
  endtask

  // one cycle: check grant now, advance, check returns of the previous cycle
  task automatic tick(input string tag, output logic [NP-1:0] g);
    logic [3:0] taken;
    logic [31:0] nd [NP];
    logic [NP-1:0] rdv;
    #1;
    taken = '0;
    g = '0;
    for (int p = 0; p < NP; p++) begin
      nd[p] = '0;
      if (req[p] && !taken[addr[p][1:0]]) begin
        taken[addr[p][1:0]] = 1'b1;
        g[p] = 1'b1;
      end
    end
    chk({tag, " gnt"}, 32'(gnt), 32'(g));
    for (int p = 0; p < NP; p++) begin
      if (g[p]) begin
        if (we[p]) begin
          for (int i = 0; i < 4; i++)
            if (be[p][i]) mdl[addr[p]][i*8 +: 8] = wdata[p][i*8 +: 8];
        end else begin
          nd[p] = mdl[addr[p]];
        end
      end
    end
    rdv = g & ~we;
    @(negedge clk);
    chk({tag, " R7 rvalid"}, 32'(rvalid), 32'(pg));
    for (int p = 0; p < NP; p++)
      if (pg[p]) chk({tag, " R7 rdata"}, rdata[p], pd[p]);
    pg = rdv;
    for (int p = 0; p < NP; p++) if (rdv[p]) pd[p] = nd[p];
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    logic [NP-1:0] g;
    logic [NP-1:0] pend;
    pg = '0;
    for (int p = 0; p < NP; p++) pd[p] = '0;
    for (int i = 0; i < DEP; i++) mdl[i] = '0;
    rst = 1'b1;
    clr();
    repeat (3) @(negedge clk);
    req = '1;
    #1;
    chk("R1 gnt in reset", 32'(gnt), 32'h0);
    chk("R1 rvalid in reset", 32'(rvalid), 32'h0);
    for (int p = 0; p < NP; p++) chk("R1 rdata in reset", rdata[p], 32'h0);
    @(negedge clk);
    clr();
    rst = 1'b0;

    // fill every word from rotating ports (R2, R3)
    for (int i = 0; i < DEP; i++) begin
      clr();
      req[i % 8] = 1'b1; we[i % 8] = 1'b1; addr[i % 8] = AW'(i);
      wdata[i % 8] = 32'h5A00_0000 ^ (32'(i) * 32'h0103_0507);
      be[i % 8] = 4'hF;
      tick("R2 R3 fill", g);
    end
    for (int i = 0; i < DEP; i++) begin
      clr();
      req[(i * 3) % 8] = 1'b1; addr[(i * 3) % 8] = AW'(i);
      tick("R2 R3 readback", g);
    end
    clr();
    tick("R2 flush", g);
    tick("R2 flush", g);

    // every requester set on one bank, served in ascending order (R5, R6)
    for (int m = 1; m < 256; m++) begin
      clr();
      for (int p = 0; p < NP; p++) begin
        if (m[p]) begin
          req[p] = 1'b1;
          addr[p] = AW'((((p + m) % 16) * 4) + (m % 4));
        end
      end
      pend = NP'(m);
      for (int k = 0; k < 9 && pend != 0; k++) begin
        tick("R5 R6 contend", g);
        req = req & ~g;
        pend = pend & ~g;
      end
    end
    clr();
    tick("R6 flush", g);
    tick("R6 flush", g);

    // spread over banks (R4)
    clr();
    for (int p = 4; p < NP; p++) begin
      req[p] = 1'b1; addr[p] = AW'(((p * 5) % 16) * 4 + (7 - p));
    end
    tick("R4 four banks", g);
    clr();
    for (int p = 0; p < NP; p++) begin
      req[p] = 1'b1; addr[p] = AW'(p * 4 + (p % 4));
      if (p >= 4) begin we[p] = 1'b1; be[p] = 4'hF; wdata[p] = 32'hC0DE_0000 + 32'(p); end
    end
    pend = '1;
    for (int k = 0; k < 3 && pend != 0; k++) begin
      tick("R4 R6 eight ports", g);
      req = req & ~g;
      pend = pend & ~g;
    end
    clr();
    for (int p = 0; p < 4; p++) begin req[p] = 1'b1; addr[p] = AW'(16 + p * 4 + p); end
    tick("R4 readback", g);
    clr();
    tick("R4 flush", g);
    tick("R4 flush", g);

    // byte enables on one word (R8, R9)
    for (int e = 0; e < 16; e++) begin
      clr();
      req[2] = 1'b1; we[2] = 1'b1; addr[2] = AW'(5); be[2] = 4'(e);
      wdata[2] = {4{8'(e * 17 + 3)}};
      tick("R8 R9 byte write", g);
      clr();
      req[7] = 1'b1; addr[7] = AW'(5);
      tick("R8 R9 byte read", g);
      clr();
      tick("R8 R9 flush", g);
      tick("R8 R9 flush", g);
    end

    summary();
    $finish;
  end
endmodule